// File: doc/BRIEF.md
# Interrupt-Priority Step Dispatcher

This block is the per-step control unit of a small multitasking processor. On every step it takes one external event and the processor's internal status, then issues exactly one action. The action is one of: service an I/O interrupt, idle, trap a task error, enter a supervisor call, preempt on the time slice, or fetch and execute. It also owns three pieces of state: the user/supervisor mode bit, the current task id and the time-slice counter. The instruction datapath, memory and handler code sit outside the block.

The action is picked by a strict fixed priority: I/O first, then wait, error, supervisor call, slice expiry, and finally execute. I/O outranks even the wait state, so a waiting machine still takes device events and does nothing else. Supervisor mode cannot be interrupted. Device events that arrive in supervisor mode are queued and serviced one per step once user mode resumes. Handler code hands control back to a task through a resume request, which also reloads the time slice.

Handler entry is signalled by a one-hot action vector together with a context-save strobe. Both are registered and appear one clock after the step that caused them.

Top module: `evt_step_dispatch`

## Requirements
- R1: After synchronous reset the block is in supervisor mode with task id 0, slice count 0, an empty pending queue, and no action or context-save output asserted.
- R2: A cycle with `step_i` high produces exactly one set bit in `act_o` on the next cycle. A cycle without a step gives `act_o` = 0. Bit positions are: 0 I/O, 1 idle, 2 trap, 3 supervisor call, 4 preempt, 5 execute.
- R3: In user mode, an available I/O event selects the I/O action above every other condition. `evt_kind_i` 1 is an input interrupt (device and character) and 2 is an output-completion interrupt (device only, character reported as 0). The action raises `ctx_save_o`, enters supervisor mode, and reports `io_in_o`, `io_dev_o` and `io_char_o`. These three hold their value until the next I/O action.
- R4: With no I/O available and `wait_i` high, the step gives idle and leaves mode, task id and slice count unchanged.
- R5: In user mode, with no I/O and no wait, a task error (`fault_i`) gives trap, context save and supervisor mode, ahead of a supervisor call and of slice expiry.
- R6: In user mode, with no I/O, wait or error, `svc_i` gives the supervisor-call action, context save and supervisor mode.
- R7: In user mode, with none of the above and a slice count of 0, the step gives preempt, context save and supervisor mode.
- R8: Otherwise a user-mode step executes and decrements the slice count by one.
- R9: In supervisor mode a step never traps, enters a call, preempts or takes I/O. It gives idle when `wait_i` is high and execute otherwise, and leaves the slice count unchanged.
- R10: An I/O event in supervisor mode is queued, up to `PEND_DEPTH` entries. Each later user-mode step services the oldest entry first. An event arriving while the queue is full is dropped.
- R11: A user-mode step that services a queued entry appends any I/O event arriving in the same step to the back of the queue.
- R12: A resume request in supervisor mode with a task id below `MAX_TASKS` (15 by default) takes effect on the next clock. It switches to user mode, loads that task id and reloads the slice count from `slice_len_i`. A resume in user mode, or one naming id 15, changes nothing.
- R13: Event codes 0 (tick) and 3 (reserved) are treated as no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | A step is taken this cycle |
| evt_kind_i | input | 2 | Event code: 0 tick, 1 input, 2 output done, 3 none |
| evt_dev_i | input | DEV_W | Device identifier of the event |
| evt_char_i | input | CHAR_W | Character carried by an input event |
| wait_i | input | 1 | No task is ready; machine waits |
| fault_i | input | 1 | Current task has an error condition |
| svc_i | input | 1 | Current instruction is a supervisor call |
| resume_i | input | 1 | Handler returns control to a task |
| resume_task_i | input | TID_W | Task id to resume |
| slice_len_i | input | SLICE_W | Slice length loaded on resume |
| act_o | output | 6 | One-hot action of the previous step |
| ctx_save_o | output | 1 | Save-context strobe on handler entry |
| io_in_o | output | 1 | Last serviced I/O was an input event |
| io_dev_o | output | DEV_W | Device of last serviced I/O |
| io_char_o | output | CHAR_W | Character of last serviced I/O |
| sup_mode_o | output | 1 | Supervisor mode |
| task_id_o | output | TID_W | Current task id |
| slice_left_o | output | SLICE_W | Remaining time slice |

## Verification
Every result of a step lands one clock after the edge that samples it. That covers the action bit, the context strobe, the mode bit, the I/O fields and the slice decrement. A resume changes mode, task id and slice on the next edge, so a queued event shows up as an I/O action two edges after the resume when the step follows at once. The bench drives inputs and compares every output at the falling edge against a behavioural model that updates on the rising edge. Each comparison therefore sees exactly the state one register stage after its stimulus. Directed sequences cover queue overflow, in-order draining with a simultaneous arrival, every rung of the priority ladder and a zero-length slice; a long random phase follows.

// File: rtl/stepd_pkg.sv
package stepd_pkg;

  typedef enum logic [1:0] {
    EV_TICK = 2'd0,
    EV_IN   = 2'd1,
    EV_OUT  = 2'd2,
    EV_RSV  = 2'd3
  } evt_kind_e;

  // Action bit positions; lower index wins.
  localparam int ACT_IO      = 0;
  localparam int ACT_IDLE    = 1;
  localparam int ACT_TRAP    = 2;
  localparam int ACT_SVC     = 3;
  localparam int ACT_PREEMPT = 4;
  localparam int ACT_EXEC    = 5;
  localparam int N_ACT       = 6;

endpackage

// File: rtl/stepd_pend_fifo.sv
module stepd_pend_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_MAX);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/stepd_slice_timer.sv
module stepd_slice_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] value,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign value   = cnt;
  assign expired = (cnt == '0);

endmodule

// File: rtl/stepd_prio_pick.sv
module stepd_prio_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic seen;

  // lowest index has highest priority
  always_comb begin
    seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i] && !seen;
      seen   = seen | req[i];
    end
  end

endmodule

// File: rtl/evt_step_dispatch.sv
module evt_step_dispatch
  import stepd_pkg::*;
#(
  parameter int DEV_W      = 3,
  parameter int CHAR_W     = 8,
  parameter int TID_W      = 4,
  parameter int MAX_TASKS  = 15,
  parameter int SLICE_W    = 8,
  parameter int PEND_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_i,
  input  logic [1:0]         evt_kind_i,
  input  logic [DEV_W-1:0]   evt_dev_i,
  input  logic [CHAR_W-1:0]  evt_char_i,
  input  logic               wait_i,
  input  logic               fault_i,
  input  logic               svc_i,
  input  logic               resume_i,
  input  logic [TID_W-1:0]   resume_task_i,
  input  logic [SLICE_W-1:0] slice_len_i,
  output logic [5:0]         act_o,
  output logic               ctx_save_o,
  output logic               io_in_o,
  output logic [DEV_W-1:0]   io_dev_o,
  output logic [CHAR_W-1:0]  io_char_o,
  output logic               sup_mode_o,
  output logic [TID_W-1:0]   task_id_o,
  output logic [SLICE_W-1:0] slice_left_o
);

  localparam int PKT_W = 1 + DEV_W + CHAR_W;
  localparam logic [TID_W-1:0] TID_LIMIT = TID_W'(MAX_TASKS);

  // registered state
  logic               sup_q;
  logic [TID_W-1:0]   tid_q;
  logic [N_ACT-1:0]   act_q;
  logic               ctx_q;
  logic               io_in_q;
  logic [DEV_W-1:0]   io_dev_q;
  logic [CHAR_W-1:0]  io_char_q;

  // step decode
  logic               evt_here;
  logic               user_m;
  logic [PKT_W-1:0]   inc_pkt;
  logic [PKT_W-1:0]   q_head;
  logic [PKT_W-1:0]   src_pkt;
  logic               q_empty, q_full;
  logic               q_push, q_pop;
  logic [N_ACT-1:0]   req, gnt;
  logic               entry;
  logic               resume_ok;
  logic               slice_dec;
  logic [SLICE_W-1:0] slice_val;
  logic               slice_exp;

  assign user_m   = !sup_q;
  assign evt_here = step_i && ((evt_kind_i == EV_IN) || (evt_kind_i == EV_OUT));
  assign inc_pkt  = {(evt_kind_i == EV_IN), evt_dev_i,
                     (evt_kind_i == EV_IN) ? evt_char_i : {CHAR_W{1'b0}}};

  // queued events are older, so they go first
  assign src_pkt = q_empty ? inc_pkt : q_head;

  // supervisor mode queues every event; user mode queues behind a backlog
  assign q_push = evt_here && (sup_q || !q_empty);
  assign q_pop  = step_i && user_m && !q_empty;

  stepd_pend_fifo #(
    .DEPTH (PEND_DEPTH),
    .W     (PKT_W)
  ) u_pend (
    .clk   (clk),
    .rst   (rst),
    .push  (q_push),
    .pop   (q_pop),
    .din   (inc_pkt),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full)
  );

  // priority ladder; handler entries are masked in supervisor mode
  assign req[ACT_IO]      = user_m && (evt_here || !q_empty);
  assign req[ACT_IDLE]    = wait_i;
  assign req[ACT_TRAP]    = user_m && fault_i;
  assign req[ACT_SVC]     = user_m && svc_i;
  assign req[ACT_PREEMPT] = user_m && slice_exp;
  assign req[ACT_EXEC]    = 1'b1;

  stepd_prio_pick #(
    .N   (N_ACT)
  ) u_pick (
    .req (req),
    .gnt (gnt)
  );

  assign entry = step_i && (gnt[ACT_IO] || gnt[ACT_TRAP] ||
                            gnt[ACT_SVC] || gnt[ACT_PREEMPT]);
  assign resume_ok = resume_i && sup_q && (resume_task_i < TID_LIMIT);
  assign slice_dec = step_i && user_m && gnt[ACT_EXEC];

  stepd_slice_timer #(
    .W        (SLICE_W)
  ) u_slice (
    .clk      (clk),
    .rst      (rst),
    .load     (resume_ok),
    .load_val (slice_len_i),
    .dec      (slice_dec),
    .value    (slice_val),
    .expired  (slice_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_q     <= 1'b1;
      tid_q     <= '0;
      act_q     <= '0;
      ctx_q     <= 1'b0;
      io_in_q   <= 1'b0;
      io_dev_q  <= '0;
      io_char_q <= '0;
    end else begin
      act_q <= step_i ? gnt : '0;
      ctx_q <= entry;
      if (entry)          sup_q <= 1'b1;
      else if (resume_ok) sup_q <= 1'b0;
      if (resume_ok) tid_q <= resume_task_i;
      if (step_i && gnt[ACT_IO]) begin
        io_in_q   <= src_pkt[PKT_W-1];
        io_dev_q  <= src_pkt[CHAR_W +: DEV_W];
        io_char_q <= src_pkt[CHAR_W-1:0];
      end
    end
  end

  assign act_o        = act_q;
  assign ctx_save_o   = ctx_q;
  assign io_in_o      = io_in_q;
  assign io_dev_o     = io_dev_q;
  assign io_char_o    = io_char_q;
  assign sup_mode_o   = sup_q;
  assign task_id_o    = tid_q;
  assign slice_left_o = slice_val;

endmodule

// File: rtl/stepd_chk.sv
module stepd_chk
  import stepd_pkg::*;
#(
  parameter int TID_W   = 4,
  parameter int SLICE_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               step_i,
  input logic [1:0]         evt_kind_i,
  input logic               wait_i,
  input logic               fault_i,
  input logic               svc_i,
  input logic               resume_i,
  input logic [5:0]         act_o,
  input logic               ctx_save_o,
  input logic               sup_mode_o,
  input logic [TID_W-1:0]   task_id_o,
  input logic [SLICE_W-1:0] slice_left_o
);

  logic io_kind;
  assign io_kind = (evt_kind_i == EV_IN) || (evt_kind_i == EV_OUT);

  // R2
  act_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    step_i |=> ($countones(act_o) == 1));

  // R2
  act_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> (act_o == '0));

  // R3
  entry_sup_chk: assert property (@(posedge clk) disable iff (rst)
    ctx_save_o |-> sup_mode_o);

  // R3
  io_first_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !sup_mode_o && io_kind) |=> (act_o[ACT_IO] && ctx_save_o));

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && wait_i && !io_kind && !resume_i) |=>
      (!act_o[ACT_TRAP] && !act_o[ACT_SVC] && !act_o[ACT_PREEMPT] &&
       !act_o[ACT_EXEC] && $stable(task_id_o)));

  // R5
  trap_rank_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !sup_mode_o && !wait_i && fault_i && !io_kind) |=>
      (act_o[ACT_TRAP] || act_o[ACT_IO]));

  // R7
  slice_out_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !sup_mode_o && !wait_i && !fault_i && !svc_i && !io_kind &&
     slice_left_o == '0) |=> (act_o[ACT_PREEMPT] || act_o[ACT_IO]));

  // R9
  sup_no_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && sup_mode_o) |=>
      (!act_o[ACT_IO] && !act_o[ACT_TRAP] && !act_o[ACT_SVC] &&
       !act_o[ACT_PREEMPT] && !ctx_save_o));

  // R9
  sup_slice_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (sup_mode_o && !resume_i) |=> $stable(slice_left_o));

  // R12
  resume_user_chk: assert property (@(posedge clk) disable iff (rst)
    (resume_i && !sup_mode_o) |=> $stable(task_id_o));

endmodule

bind evt_step_dispatch stepd_chk #(
  .TID_W        (TID_W),
  .SLICE_W      (SLICE_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .step_i       (step_i),
  .evt_kind_i   (evt_kind_i),
  .wait_i       (wait_i),
  .fault_i      (fault_i),
  .svc_i        (svc_i),
  .resume_i     (resume_i),
  .act_o        (act_o),
  .ctx_save_o   (ctx_save_o),
  .sup_mode_o   (sup_mode_o),
  .task_id_o    (task_id_o),
  .slice_left_o (slice_left_o)
);

// File: tb/evt_step_dispatch_tb.sv
module evt_step_dispatch_tb;

  localparam int DEV_W      = 3;
  localparam int CHAR_W     = 8;
  localparam int TID_W      = 4;
  localparam int MAX_TASKS  = 15;
  localparam int SLICE_W    = 8;
  localparam int PEND_DEPTH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst = 1'b1;
  logic               step_i = 1'b0;
  logic [1:0]         evt_kind_i = '0;
  logic [DEV_W-1:0]   evt_dev_i = '0;
  logic [CHAR_W-1:0]  evt_char_i = '0;
  logic               wait_i = 1'b0, fault_i = 1'b0, svc_i = 1'b0;
  logic               resume_i = 1'b0;
  logic [TID_W-1:0]   resume_task_i = '0;
  logic [SLICE_W-1:0] slice_len_i = '0;
  logic [5:0]         act_o;
  logic               ctx_save_o, io_in_o, sup_mode_o;
  logic [DEV_W-1:0]   io_dev_o;
  logic [CHAR_W-1:0]  io_char_o;
  logic [TID_W-1:0]   task_id_o;
  logic [SLICE_W-1:0] slice_left_o;

  evt_step_dispatch #(
    .DEV_W(DEV_W), .CHAR_W(CHAR_W), .TID_W(TID_W), .MAX_TASKS(MAX_TASKS),
    .SLICE_W(SLICE_W), .PEND_DEPTH(PEND_DEPTH)
  ) u_dut (
    .clk(clk), .rst(rst), .step_i(step_i), .evt_kind_i(evt_kind_i),
    .evt_dev_i(evt_dev_i), .evt_char_i(evt_char_i), .wait_i(wait_i),
    .fault_i(fault_i), .svc_i(svc_i), .resume_i(resume_i),
    .resume_task_i(resume_task_i), .slice_len_i(slice_len_i),
    .act_o(act_o), .ctx_save_o(ctx_save_o), .io_in_o(io_in_o),
    .io_dev_o(io_dev_o), .io_char_o(io_char_o), .sup_mode_o(sup_mode_o),
    .task_id_o(task_id_o), .slice_left_o(slice_left_o)
  );

  // reference model state
  int        checks = 0, bad = 0;
  bit        started = 0, done = 0;
  bit        m_sup;
  int        m_tid, m_slice;
  int        pend[$];
  logic [5:0] e_act;
  bit        e_ctx, e_in;
  int        e_dev, e_char;
  string     e_tag = "R1";

  always @(posedge clk) begin : model
    bit was_sup, io_now;
    int pkt, src;
    if (rst) begin
      m_sup = 1; m_tid = 0; m_slice = 0; pend.delete();
      e_act = '0; e_ctx = 0; e_in = 0; e_dev = 0; e_char = 0;
      e_tag = "R1";
    end else begin
      was_sup = m_sup;
      e_act = '0; e_ctx = 0; e_tag = "R2";
      if (step_i) begin
        io_now = (evt_kind_i == 2'd1) || (evt_kind_i == 2'd2);
        pkt = ((evt_kind_i == 2'd1) ? 2048 : 0) + int'(evt_dev_i) * 256 +
              ((evt_kind_i == 2'd1) ? int'(evt_char_i) : 0);
        if (m_sup) begin
          e_tag = "R9";
          if (io_now) begin
            e_tag = "R10";
            if (pend.size() < PEND_DEPTH) pend.push_back(pkt);
          end
          e_act = wait_i ? 6'b000010 : 6'b100000;
        end else if (pend.size() > 0 || io_now) begin
          if (pend.size() > 0) begin
            src = pend.pop_front();
            e_tag = "R10";
            if (io_now) begin pend.push_back(pkt); e_tag = "R11"; end
          end else begin
            src = pkt; e_tag = "R3";
          end
          e_act = 6'b000001; e_ctx = 1; m_sup = 1;
          e_in = (src / 2048) % 2 == 1;
          e_dev = (src / 256) % 8;
          e_char = src % 256;
        end else if (wait_i) begin
          e_act = 6'b000010; e_tag = "R4";
        end else if (fault_i) begin
          e_act = 6'b000100; e_ctx = 1; m_sup = 1; e_tag = "R5";
        end else if (svc_i) begin
          e_act = 6'b001000; e_ctx = 1; m_sup = 1; e_tag = "R6";
        end else if (m_slice == 0) begin
          e_act = 6'b010000; e_ctx = 1; m_sup = 1; e_tag = "R7";
        end else begin
          e_act = 6'b100000; m_slice = m_slice - 1;
          e_tag = (evt_kind_i == 2'd3 || evt_kind_i == 2'd0) ? "R13" : "R8";
        end
      end
      if (resume_i) begin
        e_tag = "R12";
        if (was_sup && int'(resume_task_i) < MAX_TASKS) begin
          m_sup = 0; m_tid = int'(resume_task_i); m_slice = int'(slice_len_i);
        end
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (act_o !== e_act || ctx_save_o !== e_ctx || sup_mode_o !== m_sup ||
          task_id_o !== TID_W'(m_tid) || slice_left_o !== SLICE_W'(m_slice) ||
          io_in_o !== e_in || io_dev_o !== DEV_W'(e_dev) ||
          io_char_o !== CHAR_W'(e_char)) begin
        bad++;
        $display("FAIL %s: act=%b/%b ctx=%b/%b sup=%b/%b tid=%0d/%0d slice=%0d/%0d io=%b,%0d,%0d/%b,%0d,%0d",
                 e_tag, act_o, e_act, ctx_save_o, e_ctx, sup_mode_o, m_sup,
                 task_id_o, m_tid, slice_left_o, m_slice,
                 io_in_o, io_dev_o, io_char_o, e_in, e_dev, e_char);
      end
    end
  end

  task automatic drv(input bit st, input int kind, input int dev, input int ch,
                     input bit wt, input bit flt, input bit sv,
                     input bit rs, input int rt);
    step_i = st; evt_kind_i = 2'(kind); evt_dev_i = DEV_W'(dev);
    evt_char_i = CHAR_W'(ch); wait_i = wt; fault_i = flt; svc_i = sv;
    resume_i = rs; resume_task_i = TID_W'(rt);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;                                 // R1 checked by model during reset
    slice_len_i = 8'd3;
    drv(1, 0, 0, 0, 0, 0, 0, 0, 0);          // R9 exec
    drv(1, 0, 0, 0, 1, 1, 1, 0, 0);          // R9 idle, no trap
    // R10: five events in supervisor mode, fifth dropped
    drv(1, 1, 2, 'h41, 0, 0, 0, 0, 0);
    drv(1, 2, 5, 'h99, 0, 0, 0, 0, 0);
    drv(1, 1, 7, 'h5A, 1, 0, 0, 0, 0);
    drv(1, 1, 1, 'h33, 0, 0, 0, 0, 0);
    drv(1, 2, 4, 0, 0, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 0, 0, 0, 1, 15);         // R12 id 15 ignored
    for (int i = 0; i < 5; i++) begin
      drv(0, 0, 0, 0, 0, 0, 0, 1, 2);
      if (i == 1) drv(1, 1, 3, 'h77, 1, 0, 0, 0, 0);   // R11
      else        drv(1, 0, 0, 0, 1, 1, 0, 0, 0);
    end
    drv(0, 0, 0, 0, 0, 0, 0, 1, 5);          // R12 resume task 5
    drv(1, 3, 6, 'hFF, 0, 0, 0, 0, 0);       // R13 reserved code
    drv(1, 0, 0, 0, 0, 0, 0, 0, 0);          // R8
    drv(1, 0, 0, 0, 0, 0, 0, 0, 0);          // R8
    drv(1, 0, 0, 0, 0, 0, 0, 0, 0);          // R7 preempt
    drv(0, 0, 0, 0, 0, 0, 0, 1, 7);
    drv(1, 0, 0, 0, 1, 1, 1, 0, 0);          // R4 idle in user
    drv(1, 0, 0, 0, 0, 1, 1, 0, 0);          // R5 trap
    drv(0, 0, 0, 0, 0, 0, 0, 1, 8);
    drv(1, 0, 0, 0, 0, 0, 1, 0, 0);          // R6
    drv(0, 0, 0, 0, 0, 0, 0, 1, 9);
    drv(0, 0, 0, 0, 0, 0, 0, 1, 4);          // R12 ignored in user
    drv(1, 1, 6, 'h10, 1, 1, 1, 0, 0);       // R3 outranks all
    slice_len_i = 8'd0;
    drv(0, 0, 0, 0, 0, 0, 0, 1, 14);
    drv(1, 0, 0, 0, 0, 0, 0, 0, 0);          // R7 zero slice
    for (int n = 0; n < 4000; n++) begin
      slice_len_i = SLICE_W'($urandom_range(0, 5));
      drv(($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)),
          int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
          ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0),
          ($urandom_range(0, 9) == 0), ($urandom_range(0, 3) == 0),
          int'($urandom_range(0, 15)));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule